// File: doc/BRIEF.md
# Configurable Asynchronous Frame Receiver

This block turns an asynchronous serial input line into characters. A clock enable pulse, `tick_i`, arrives sixteen times per bit period (the ratio is set by a parameter). The line is first passed through a synchronizer. The block then waits for a falling edge and takes each bit by majority vote at the middle of its bit time. It assembles the payload least significant bit first and checks the stop bits. Each finished character goes out on a valid/ready output port.

Static configuration inputs choose the frame layout:

- **Payload length:** 8 or 9 payload bits.
- **Top payload bit:** it can stay data, or be reused as a parity bit, or be reused as an address mark.
- **Receive-only dual-stop format:** an 8-bit or 12-bit character followed by a parity bit and two stop bits.

The layout is captured when a start bit is accepted. A configuration change therefore affects only the next frame.

Back-pressure on the output port works as follows:

- A character waits in a single holding stage until the consumer raises `out_ready` while `out_valid` is high.
- While it waits, all output fields stay frozen.
- A character that completes while the holding stage is still full is discarded. The event is reported by a one-cycle `overrun_o` pulse.
- A new character that completes in the same cycle as an acceptance is kept.

Top module: `sci_frame_rx`

## Requirements
- R1: After reset `out_valid` is 0 and `overrun_o` is 0, and the receiver hunts for a start bit on an idle-high line.
- R2: When `cfg_nine`=0 and the parity, address and dual-stop modes are off, a frame is one low start bit, 8 data bits sent least significant bit first, and one stop bit. The character appears in `out_data[7:0]`, and bits 11:8 read 0.
- R3: When `cfg_nine`=1 and the parity, address and dual-stop modes are off, the frame carries 9 data bits. They appear in `out_data[8:0]` with the upper bits at 0.
- R4: When `cfg_par_en`=1 and dual-stop is off, the last payload position is the parity bit. The character is then 7 bits (`cfg_nine`=0) or 8 bits (`cfg_nine`=1). With `cfg_par_odd`=0 the character bits plus the parity bit must hold an even number of ones; with `cfg_par_odd`=1 they must hold an odd number. On a mismatch, `out_perr` is 1 in the same word as `out_valid`.
- R5: When `cfg_addr_en`=1, `cfg_par_en`=0 and dual-stop is off, the last payload position is an address mark. It is reported on `out_addr` (1 when the bit was 1) and is not placed in `out_data`. `cfg_par_en` takes priority over `cfg_addr_en`. `out_addr` is 0 in every other layout.
- R6: When `cfg_dual_stop`=1, the frame carries 12 character bits (`cfg_wide`=1) or 8 character bits (`cfg_wide`=0), then a parity bit checked as in R4, then two stop bits. This mode overrides `cfg_nine`, `cfg_par_en` and `cfg_addr_en`.
- R7: If any expected stop bit samples low, `out_ferr` is 1 in the delivered word. The character is still delivered. In dual-stop mode either stop bit being low sets it.
- R8: A start bit whose mid-bit vote reads high is treated as noise. No word is produced and the receiver returns to hunting.
- R9: Each bit value is the majority of oversampling samples 7, 8 and 9, counted from the sample that saw the falling edge as sample 0. A single sample of the opposite level inside a bit does not change the received value.
- R10: While `out_valid`=1 and `out_ready`=0, `out_data`, `out_addr`, `out_perr` and `out_ferr` stay stable and `out_valid` stays 1. A cycle with both high consumes the word.
- R11: If a character completes while a word is held and not being accepted, `overrun_o` pulses for one cycle. The new character is discarded and the held word is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Oversampling enable, sixteen pulses per bit time |
| rx_i | input | 1 | Serial line, idle high |
| cfg_nine | input | 1 | 9 payload bits when 1, 8 when 0 |
| cfg_par_en | input | 1 | Top payload bit is parity |
| cfg_addr_en | input | 1 | Top payload bit is an address mark (parity off) |
| cfg_par_odd | input | 1 | Odd parity when 1, even when 0 |
| cfg_dual_stop | input | 1 | Receive-only format: character, parity, two stop bits |
| cfg_wide | input | 1 | 12-bit character in dual-stop format |
| out_valid | output | 1 | Held word is valid |
| out_ready | input | 1 | Consumer accepts the held word |
| out_data | output | 12 | Character, right-aligned, upper bits zero |
| out_addr | output | 1 | Address mark of the word |
| out_perr | output | 1 | Parity mismatch in the word |
| out_ferr | output | 1 | A stop bit sampled low |
| overrun_o | output | 1 | One-cycle pulse when a character was discarded |

## Verification
The assertions rely on three things:

- The configuration inputs change only between frames.
- Ticks are spaced widely enough that the sampler's registered vote strobe is handled before the next vote.
- The consumer may drive `out_ready` freely.

The bench follows these rules. It pulses `tick_i` once every fourth clock, which is longer than the synchronizer delay. It changes `rx_i` only just after a tick, so that every bit spans exactly sixteen ticks. It changes the configuration only while the line is idle. After every frame it keeps the line high for twenty ticks. This lets a frame with a low final stop bit settle without a false start being accepted.

// File: rtl/sfr_pkg.sv
package sfr_pkg;
  localparam int CHAR_MAX = 12;
  localparam int IDX_W = $clog2(CHAR_MAX + 4);

  typedef logic [CHAR_MAX-1:0] char_t;

  typedef struct packed {
    logic [IDX_W-1:0] nchar;
    logic             has_extra;
    logic             extra_par;
    logic             dual_stop;
  } layout_t;

  // Dual-stop wins over parity, parity wins over address mark.
  function automatic layout_t pick_layout(input logic nine, input logic dual,
                                          input logic wide, input logic par_en,
                                          input logic addr_en);
    layout_t l;
    logic [IDX_W-1:0] base;
    base = nine ? IDX_W'(9) : IDX_W'(8);
    if (dual) begin
      l.nchar     = wide ? IDX_W'(12) : IDX_W'(8);
      l.has_extra = 1'b1;
      l.extra_par = 1'b1;
      l.dual_stop = 1'b1;
    end else if (par_en) begin
      l.nchar     = base - IDX_W'(1);
      l.has_extra = 1'b1;
      l.extra_par = 1'b1;
      l.dual_stop = 1'b0;
    end else if (addr_en) begin
      l.nchar     = base - IDX_W'(1);
      l.has_extra = 1'b1;
      l.extra_par = 1'b0;
      l.dual_stop = 1'b0;
    end else begin
      l.nchar     = base;
      l.has_extra = 1'b0;
      l.extra_par = 1'b0;
      l.dual_stop = 1'b0;
    end
    return l;
  endfunction
endpackage

// File: rtl/sfr_bit_sampler.sv
module sfr_bit_sampler #(
  parameter int OVERSAMPLE  = 16,
  parameter int VOTE_MID    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic rx_i,
  input  logic release_i,
  output logic bit_stb_o,
  output logic bit_val_o,
  output logic busy_o
);
  localparam int PH_W = $clog2(OVERSAMPLE);
  localparam logic [PH_W-1:0] PH_A    = PH_W'(VOTE_MID - 1);
  localparam logic [PH_W-1:0] PH_B    = PH_W'(VOTE_MID);
  localparam logic [PH_W-1:0] PH_C    = PH_W'(VOTE_MID + 1);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(OVERSAMPLE - 1);

  logic rx_s;

  generate
    if (SYNC_STAGES == 0) begin : g_nosync
      assign rx_s = rx_i;
    end else begin : g_sync
      logic [SYNC_STAGES-1:0] sq;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sq <= '1;
        else        sq <= (sq << 1) | SYNC_STAGES'(rx_i);
      end
      assign rx_s = sq[SYNC_STAGES-1];
    end
  endgenerate

  logic            active_q;
  logic [PH_W-1:0] phase_q;
  logic            vote_a_q, vote_b_q;
  logic            majority;

  assign majority = (vote_a_q & vote_b_q) | (vote_a_q & rx_s) | (vote_b_q & rx_s);
  assign busy_o   = active_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q  <= 1'b0;
      phase_q   <= '0;
      vote_a_q  <= 1'b1;
      vote_b_q  <= 1'b1;
      bit_stb_o <= 1'b0;
      bit_val_o <= 1'b1;
    end else begin
      bit_stb_o <= 1'b0;
      if (release_i) begin
        active_q <= 1'b0;
      end else if (tick_i) begin
        if (!active_q) begin
          if (!rx_s) begin
            active_q <= 1'b1;
            phase_q  <= PH_W'(1);
          end
        end else begin
          phase_q <= (phase_q == PH_LAST) ? '0 : phase_q + PH_W'(1);
          if (phase_q == PH_A) vote_a_q <= rx_s;
          if (phase_q == PH_B) vote_b_q <= rx_s;
          if (phase_q == PH_C) begin
            bit_stb_o <= 1'b1;
            bit_val_o <= majority;
          end
        end
      end
    end
  end

  // R9
  vote_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_stb_o |-> $past(tick_i) && $past(active_q));

  // R8
  hunt_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active_q) |-> $past(!rx_s) && $past(tick_i));
endmodule

// File: rtl/sfr_frame_ctrl.sv
module sfr_frame_ctrl
  import sfr_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    bit_stb_i,
  input  logic    bit_val_i,
  input  layout_t layout_i,
  input  logic    par_odd_i,
  output logic    release_o,
  output logic    done_o,
  output char_t   char_o,
  output logic    addr_o,
  output logic    perr_o,
  output logic    ferr_o
);
  localparam int PAY_W = CHAR_MAX + 1;

  logic [IDX_W-1:0] idx_q;
  layout_t          lay_q;
  logic             odd_q;
  logic [PAY_W-1:0] pay_q;
  logic             ferr_q;

  logic [IDX_W-1:0] pay_n, last_n;
  logic             in_start, in_pay, at_last;
  logic [PAY_W-1:0] mask_w;
  char_t            chr_w;
  logic             extra_w;

  assign pay_n    = lay_q.nchar + IDX_W'(lay_q.has_extra);
  assign last_n   = pay_n + (lay_q.dual_stop ? IDX_W'(2) : IDX_W'(1));
  assign in_start = (idx_q == '0);
  assign in_pay   = !in_start && (idx_q <= pay_n);
  assign at_last  = !in_start && (idx_q == last_n);
  assign mask_w   = (PAY_W'(1) << lay_q.nchar) - PAY_W'(1);
  assign chr_w    = char_t'(pay_q & mask_w);
  assign extra_w  = pay_q[lay_q.nchar];

  assign release_o = bit_stb_i && (in_start ? bit_val_i : at_last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      lay_q  <= '0;
      odd_q  <= 1'b0;
      pay_q  <= '0;
      ferr_q <= 1'b0;
      done_o <= 1'b0;
      char_o <= '0;
      addr_o <= 1'b0;
      perr_o <= 1'b0;
      ferr_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (bit_stb_i) begin
        if (in_start) begin
          if (!bit_val_i) begin
            idx_q  <= IDX_W'(1);
            lay_q  <= layout_i;
            odd_q  <= par_odd_i;
            pay_q  <= '0;
            ferr_q <= 1'b0;
          end
        end else if (in_pay) begin
          pay_q[idx_q - IDX_W'(1)] <= bit_val_i;
          idx_q <= idx_q + IDX_W'(1);
        end else if (at_last) begin
          idx_q  <= '0;
          done_o <= 1'b1;
          char_o <= chr_w;
          addr_o <= lay_q.has_extra & ~lay_q.extra_par & extra_w;
          perr_o <= lay_q.extra_par & (^chr_w ^ extra_w ^ odd_q);
          ferr_o <= ferr_q | ~bit_val_i;
        end else begin
          ferr_q <= ~bit_val_i;
          idx_q  <= idx_q + IDX_W'(1);
        end
      end
    end
  end

  // R6
  idx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_q != '0) |-> (idx_q <= last_n));

  // R7
  done_after_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(bit_stb_i) && $past(release_o));

  // R4
  perr_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && perr_o) |-> lay_q.extra_par);
endmodule

// File: rtl/sfr_out_stage.sv
module sfr_out_stage
  import sfr_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  done_i,
  input  char_t char_i,
  input  logic  addr_i,
  input  logic  perr_i,
  input  logic  ferr_i,
  output logic  out_valid,
  input  logic  out_ready,
  output char_t out_data,
  output logic  out_addr,
  output logic  out_perr,
  output logic  out_ferr,
  output logic  overrun_o
);
  logic blocked;
  assign blocked = out_valid && !out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_addr  <= 1'b0;
      out_perr  <= 1'b0;
      out_ferr  <= 1'b0;
      overrun_o <= 1'b0;
    end else begin
      overrun_o <= 1'b0;
      if (done_i) begin
        if (blocked) begin
          overrun_o <= 1'b1;
        end else begin
          out_valid <= 1'b1;
          out_data  <= char_i;
          out_addr  <= addr_i;
          out_perr  <= perr_i;
          out_ferr  <= ferr_i;
        end
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  // R10
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid && $stable(out_data) &&
      $stable(out_addr) && $stable(out_perr) && $stable(out_ferr));

  // R11
  overrun_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overrun_o |-> out_valid && $past(out_valid) && $past(!out_ready));

  // R5
  addr_par_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !(out_addr && out_perr));
endmodule

// File: rtl/sci_frame_rx.sv
module sci_frame_rx
  import sfr_pkg::*;
#(
  parameter int OVERSAMPLE  = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick_i,
  input  logic                rx_i,
  input  logic                cfg_nine,
  input  logic                cfg_par_en,
  input  logic                cfg_addr_en,
  input  logic                cfg_par_odd,
  input  logic                cfg_dual_stop,
  input  logic                cfg_wide,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [CHAR_MAX-1:0] out_data,
  output logic                out_addr,
  output logic                out_perr,
  output logic                out_ferr,
  output logic                overrun_o
);
  localparam int VOTE_MID = OVERSAMPLE / 2;

  logic    bit_stb, bit_val, busy, release_w;
  logic    done_w, addr_w, perr_w, ferr_w;
  char_t   char_w;
  layout_t layout_w;

  assign layout_w = pick_layout(cfg_nine, cfg_dual_stop, cfg_wide, cfg_par_en, cfg_addr_en);

  sfr_bit_sampler #(
    .OVERSAMPLE (OVERSAMPLE),
    .VOTE_MID   (VOTE_MID),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_samp (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_i   (tick_i),
    .rx_i     (rx_i),
    .release_i(release_w),
    .bit_stb_o(bit_stb),
    .bit_val_o(bit_val),
    .busy_o   (busy)
  );

  sfr_frame_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .bit_stb_i(bit_stb),
    .bit_val_i(bit_val),
    .layout_i (layout_w),
    .par_odd_i(cfg_par_odd),
    .release_o(release_w),
    .done_o   (done_w),
    .char_o   (char_w),
    .addr_o   (addr_w),
    .perr_o   (perr_w),
    .ferr_o   (ferr_w)
  );

  sfr_out_stage u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .done_i   (done_w),
    .char_i   (char_w),
    .addr_i   (addr_w),
    .perr_i   (perr_w),
    .ferr_i   (ferr_w),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_data (out_data),
    .out_addr (out_addr),
    .out_perr (out_perr),
    .out_ferr (out_ferr),
    .overrun_o(overrun_o)
  );

  // R1
  busy_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    release_w |=> !busy);
endmodule

// File: tb/sci_frame_rx_test.sv
`timescale 1ns/1ps
module sci_frame_rx_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_i;
  logic rx_i = 1'b1;
  logic cfg_nine = 0, cfg_par_en = 0, cfg_addr_en = 0, cfg_par_odd = 0;
  logic cfg_dual_stop = 0, cfg_wide = 0;
  logic out_valid, out_ready = 1'b0;
  logic [11:0] out_data;
  logic out_addr, out_perr, out_ferr, overrun_o;
  logic [1:0] tdiv = 2'd0;
  int checks = 0, failures = 0, ovr_cnt = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) tdiv <= tdiv + 2'd1;
  assign tick_i = (tdiv == 2'd3);
  always @(negedge clk) if (overrun_o) ovr_cnt++;

  sci_frame_rx uut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .rx_i(rx_i),
    .cfg_nine(cfg_nine), .cfg_par_en(cfg_par_en), .cfg_addr_en(cfg_addr_en),
    .cfg_par_odd(cfg_par_odd), .cfg_dual_stop(cfg_dual_stop), .cfg_wide(cfg_wide),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_addr(out_addr), .out_perr(out_perr), .out_ferr(out_ferr),
    .overrun_o(overrun_o));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic int exp_nchar();
    if (cfg_dual_stop) return cfg_wide ? 12 : 8;
    return (cfg_nine ? 9 : 8) - ((cfg_par_en || cfg_addr_en) ? 1 : 0);
  endfunction
  function automatic bit exp_extra();
    return cfg_dual_stop || cfg_par_en || cfg_addr_en;
  endfunction
  function automatic bit exp_is_par();
    return cfg_dual_stop || cfg_par_en;
  endfunction
  function automatic logic [11:0] mask_n();
    return 12'((13'd1 << exp_nchar()) - 13'd1);
  endfunction
  function automatic logic good_par(input logic [11:0] d);
    return (^(d & mask_n())) ^ cfg_par_odd;
  endfunction

  task automatic line(input logic lvl, input int n);
    int k = 0;
    rx_i = lvl;
    while (k < n) begin
      @(negedge clk);
      if (tick_i) k++;
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic send_bit(input logic v, input bit glitch);
    if (glitch) begin line(v, 8); line(~v, 1); line(v, 7); end
    else line(v, 16);
  endtask

  task automatic send_frame(input logic [11:0] d, input logic e, input logic s1,
                            input logic s2, input int glitch);
    int n = exp_nchar();
    send_bit(1'b0, 0);
    for (int i = 0; i < n; i++) send_bit(d[i], i == glitch);
    if (exp_extra()) send_bit(e, 0);
    send_bit(s1, 0);
    if (cfg_dual_stop) send_bit(s2, 0);
    line(1'b1, 20);
  endtask

  task automatic take(input string req);
    @(negedge clk); out_ready = 1'b1;
    @(negedge clk); out_ready = 1'b0;
    check(req, out_valid, 0);
  endtask

  task automatic expect_word(input string req, input logic [11:0] d, input logic e,
                             input logic s1, input logic s2);
    logic [11:0] ed;
    logic ea, ep, ef;
    ed = d & mask_n();
    ea = exp_extra() && !exp_is_par() && e;
    ep = exp_is_par() && ((^ed) ^ e ^ cfg_par_odd);
    ef = !s1 || (cfg_dual_stop && !s2);
    check({req, " valid"}, out_valid, 1);
    check({req, " data"}, out_data, ed);
    check({req, " addr"}, out_addr, ea);
    check({req, " perr"}, out_perr, ep);
    check({req, " ferr"}, out_ferr, ef);
    take({req, " R10 consume"});
  endtask

  task automatic set_cfg(input logic nine, pe, ae, odd, dual, wide);
    cfg_nine = nine; cfg_par_en = pe; cfg_addr_en = ae;
    cfg_par_odd = odd; cfg_dual_stop = dual; cfg_wide = wide;
  endtask

  task automatic frame_case(input string req, input logic [11:0] d, input logic e,
                            input logic s1, input logic s2, input int glitch);
    send_frame(d, e, s1, s2, glitch);
    expect_word(req, d, e, s1, s2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int o0;
    logic [11:0] d;
    logic e, s1, s2;
    void'($urandom(32'd20240611));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 valid after reset", out_valid, 0);
    check("R1 overrun after reset", overrun_o, 0);
    line(1'b1, 20);

    set_cfg(0, 0, 0, 0, 0, 0);
    frame_case("R2 8-bit", 12'h0A5, 0, 1, 1, -1);
    frame_case("R2 8-bit ones", 12'h0FF, 0, 1, 1, -1);
    set_cfg(1, 0, 0, 0, 0, 0);
    frame_case("R3 9-bit", 12'h1C3, 0, 1, 1, -1);
    set_cfg(0, 1, 0, 0, 0, 0);
    frame_case("R4 even ok", 12'h055, good_par(12'h055), 1, 1, -1);
    frame_case("R4 even bad", 12'h055, ~good_par(12'h055), 1, 1, -1);
    set_cfg(1, 1, 1, 1, 0, 0);
    frame_case("R4 odd 9-bit bad", 12'h0B2, ~good_par(12'h0B2), 1, 1, -1);
    frame_case("R4 odd 9-bit ok", 12'h0B2, good_par(12'h0B2), 1, 1, -1);
    set_cfg(1, 0, 1, 0, 0, 0);
    frame_case("R5 addr mark", 12'h03C, 1, 1, 1, -1);
    frame_case("R5 data only", 12'h0C3, 0, 1, 1, -1);
    set_cfg(0, 0, 0, 0, 1, 1);
    frame_case("R6 wide dual-stop", 12'hABC, good_par(12'hABC), 1, 1, -1);
    set_cfg(1, 0, 1, 1, 1, 0);
    frame_case("R6 narrow dual-stop bad par", 12'h05A, ~good_par(12'h05A), 1, 1, -1);
    set_cfg(0, 0, 0, 0, 0, 0);
    frame_case("R7 stop low", 12'h03E, 0, 0, 1, -1);
    set_cfg(0, 0, 0, 0, 1, 1);
    frame_case("R7 second stop low", 12'h123, good_par(12'h123), 1, 0, -1);
    frame_case("R7 first stop low", 12'h456, good_par(12'h456), 0, 1, -1);

    set_cfg(0, 0, 0, 0, 0, 0);
    o0 = ovr_cnt;
    line(1'b0, 4);
    line(1'b1, 30);
    check("R8 noise no word", out_valid, 0);
    check("R8 noise no overrun", ovr_cnt - o0, 0);
    frame_case("R8 frame after noise", 12'h069, 0, 1, 1, -1);

    frame_case("R9 glitch bit3", 12'h0F7, 0, 1, 1, 3);
    frame_case("R9 glitch bit0", 12'h000, 0, 1, 1, 0);

    send_frame(12'h0D2, 0, 1, 1, -1);
    repeat (25) @(negedge clk);
    check("R10 held valid", out_valid, 1);
    check("R10 held data", out_data, 12'h0D2);
    take("R10 consume");

    o0 = ovr_cnt;
    send_frame(12'h011, 0, 1, 1, -1);
    send_frame(12'h022, 0, 1, 1, -1);
    check("R11 overrun pulses", ovr_cnt - o0, 1);
    check("R11 held data kept", out_data, 12'h011);
    take("R11 consume");

    for (int t = 0; t < 22; t++) begin
      set_cfg(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
              ($urandom % 4) == 0, 1'($urandom));
      d  = 12'($urandom);
      e  = 1'($urandom);
      s1 = ($urandom % 6) != 0;
      s2 = ($urandom % 6) != 0;
      frame_case("R2 R6 R7 random", d, e, s1, s2, ($urandom % 3 == 0) ? int'($urandom % 8) : -1);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule